// File: doc/BRIEF.md
# Pipelined Booth Signed Multiplier

This block multiplies two two's-complement operands of configurable width and returns the complete signed product. It does not truncate or saturate. The datapath has three parts. First, a radix-4 Booth recoder turns the multiplier operand into a set of shifted partial-product rows. Next, a tree of 3:2 carry-save compressors reduces those rows to two. Finally, a parallel-prefix carry-lookahead adder adds the last two rows, with a carry-in of zero.

A parameter sets the latency to zero, one or two register stages. With zero stages the path from operands to product is purely combinational. With one stage, the two carry-save rows are registered before the final adder. With two stages, the adder sum is also registered before it reaches the output. Every pipeline register loads only on a rising clock edge where the clock enable is high, so a low enable freezes the whole pipe. The datapath registers have no reset. The product is meaningful only after enough enabled edges have passed to fill the pipe.

The operand widths are checked at elaboration. The X width must be at least 4, the Y width must be at least the X width, and the stage count must lie in the range 0 to 2. Any other setting stops elaboration.

Top module: `booth_mul`

## Requirements
- R1: For every pair of 4-bit signed operands, the output equals their exact signed product, sign-extended to the full 8-bit output width.
- R2: Extreme operands produce exact results with no overflow. The most negative X times the most negative Y gives +2^(XW+YW-2). -1 times the most negative Y gives +2^(YW-1). The most negative X times the most positive Y is also exact.
- R3: With STAGES = 0, the output reflects the operands present in the same cycle, with no clock edge in between.
- R4: With STAGES = 1, after each rising edge where ce is high, the output shows the product of the operands sampled at that edge.
- R5: With STAGES = 2, after each enabled rising edge, the output shows the product of the operands sampled at the previous enabled edge.
- R6: While ce is low, no pipeline register changes, and with STAGES of 1 or 2 the output stays constant across clock edges.
- R7: Under random operands and random ce stalls at wide widths, results come out in order, with none lost and none repeated.
- R8: When either operand is zero, the product is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; pipeline registers load on its rising edge |
| ce | input | 1 | Clock enable shared by every pipeline register |
| a_in | input | XW | Signed X operand (Booth-recoded side) |
| b_in | input | YW | Signed Y operand |
| p_out | output | XW+YW | Full signed product |

## Verification
Suppose a single Booth row selects the wrong multiple, or a compressor drops a carry. The product is then wrong by a power of two for some operand pairs. That error appears at the output after the configured latency: in the same cycle with no stages, or after one or two enabled edges otherwise. A register that ignores the enable shows up in one of two ways. The output may change during a stall, or results may come out shifted by one position in the expected stream. Both show up within one or two cycles of the stall. The bench sweeps every 4-bit operand pair, drives extreme values at wide widths, and mixes random stalls into random traffic. This exposes faults that depend on the operands as well as faults in the timing.

// File: rtl/booth_mul_pkg.sv
package booth_mul_pkg;

   // Booth digit selection for one 3-bit window of the multiplier operand
   typedef struct packed {
      logic neg;   // subtract the selected multiple
      logic one;   // select 1x of Y
      logic two;   // select 2x of Y
   } booth_sel_t;

   function automatic booth_sel_t booth_decode(input logic [2:0] win);
      booth_sel_t s;
      s.one = win[0] ^ win[1];
      s.two = (win == 3'b011) || (win == 3'b100);
      s.neg = win[2] & ~(win[1] & win[0]);
      return s;
   endfunction

   // rows left after one layer of 3:2 compression
   function automatic int csa_next(input int n);
      return 2 * (n / 3) + (n % 3);
   endfunction

   // rows present at a given layer of the tree
   function automatic int csa_count(input int n0, input int lvl);
      int n;
      n = n0;
      for (int i = 0; i < lvl; i++) n = csa_next(n);
      return n;
   endfunction

   // layers needed to reach two rows
   function automatic int csa_depth(input int n0);
      int n;
      int d;
      n = n0;
      d = 0;
      while (n > 2) begin
         n = csa_next(n);
         d++;
      end
      return d;
   endfunction

endpackage

// File: rtl/booth_pp_rows.sv
module booth_pp_rows
   import booth_mul_pkg::*;
#(
   parameter int XW = 16,
   parameter int YW = 16,
   localparam int PW = XW + YW,
   localparam int NR = (XW + 1) / 2
)(
   input  logic [XW-1:0] x_i,
   input  logic [YW-1:0] y_i,
   output logic [PW-1:0] rows_o [0:NR]
);

   // X widened: a zero below bit 0, sign copies above the top bit
   logic [XW+1:0] x_ext;
   logic [PW-1:0] y_ext;
   logic [PW-1:0] neg_row;
   logic [NR-1:0] neg_bits;

   assign x_ext = {x_i[XW-1], x_i, 1'b0};
   assign y_ext = {{XW{y_i[YW-1]}}, y_i};

   for (genvar k = 0; k < NR; k++) begin : g_row
      booth_sel_t    sel;
      logic [PW-1:0] mag;
      logic [PW-1:0] signed_mag;

      assign sel        = booth_decode(x_ext[2*k+2 : 2*k]);
      assign mag        = sel.two ? {y_ext[PW-2:0], 1'b0} :
                          sel.one ? y_ext : '0;
      assign signed_mag = sel.neg ? ~mag : mag;
      assign rows_o[k]  = signed_mag << (2 * k);
      assign neg_bits[k] = sel.neg;
   end

   // the +1 of each negated row sits at that row's weight
   always_comb begin
      neg_row = '0;
      for (int k = 0; k < NR; k++) neg_row[2*k] = neg_bits[k];
   end

   assign rows_o[NR] = neg_row;

endmodule

// File: rtl/csa32.sv
module csa32 #(
   parameter int W = 32
)(
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic [W-1:0] c_i,
   output logic [W-1:0] sum_o,
   output logic [W-1:0] cry_o
);

   logic [W-2:0] maj;

   assign sum_o = a_i ^ b_i ^ c_i;
   assign maj   = (a_i[W-2:0] & b_i[W-2:0]) |
                  (b_i[W-2:0] & c_i[W-2:0]) |
                  (a_i[W-2:0] & c_i[W-2:0]);
   assign cry_o = {maj, 1'b0};

endmodule

// File: rtl/csa_tree.sv
module csa_tree
   import booth_mul_pkg::*;
#(
   parameter int W = 32,
   parameter int N = 9,
   localparam int D = csa_depth(N)
)(
   input  logic [W-1:0] rows_i [0:N-1],
   output logic [W-1:0] row0_o,
   output logic [W-1:0] row1_o
);

   logic [W-1:0] st [0:D][0:N-1];

   for (genvar j = 0; j < N; j++) begin : g_in
      assign st[0][j] = rows_i[j];
   end

   for (genvar l = 0; l < D; l++) begin : g_lvl
      localparam int NC = csa_count(N, l);
      localparam int G  = NC / 3;
      localparam int NN = csa_next(NC);

      for (genvar k = 0; k < G; k++) begin : g_cmp
         csa32 #(.W(W)) cmp_i (
            .a_i   (st[l][3*k]),
            .b_i   (st[l][3*k+1]),
            .c_i   (st[l][3*k+2]),
            .sum_o (st[l+1][2*k]),
            .cry_o (st[l+1][2*k+1])
         );
      end

      for (genvar j = 2 * G; j < N; j++) begin : g_slot
         if (j < NN) begin : g_pass
            assign st[l+1][j] = st[l][3*G + (j - 2*G)];
         end else begin : g_idle
            assign st[l+1][j] = '0;
         end
      end
   end

   assign row0_o = st[D][0];
   assign row1_o = st[D][1];

endmodule

// File: rtl/prefix_adder.sv
module prefix_adder #(
   parameter int W  = 32,
   localparam int N  = W - 1,
   localparam int LV = (N > 1) ? $clog2(N) : 1
)(
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   output logic [W-1:0] s_o
);

   logic [N-1:0] gl [0:LV];
   logic [N-1:0] pl [0:LV-1];

   // carry-in is zero, so bit 0 generates only from its own inputs
   assign gl[0] = a_i[N-1:0] & b_i[N-1:0];
   assign pl[0] = a_i[N-1:0] ^ b_i[N-1:0];

   for (genvar s = 0; s < LV; s++) begin : g_lvl
      localparam int DST = 1 << s;
      for (genvar i = 0; i < N; i++) begin : g_bit
         if (i >= DST) begin : g_merge
            assign gl[s+1][i] = gl[s][i] | (pl[s][i] & gl[s][i-DST]);
            if (s + 1 < LV) begin : g_p
               assign pl[s+1][i] = pl[s][i] & pl[s][i-DST];
            end
         end else begin : g_keep
            assign gl[s+1][i] = gl[s][i];
            if (s + 1 < LV) begin : g_p
               assign pl[s+1][i] = pl[s][i];
            end
         end
      end
   end

   assign s_o = (a_i ^ b_i) ^ {gl[LV], 1'b0};

endmodule

// File: rtl/booth_mul.sv
module booth_mul
   import booth_mul_pkg::*;
#(
   parameter int XW     = 16,
   parameter int YW     = 16,
   parameter int STAGES = 2
)(
   input  logic              clk,
   input  logic              ce,
   input  logic [XW-1:0]     a_in,
   input  logic [YW-1:0]     b_in,
   output logic [XW+YW-1:0]  p_out
);

   localparam int PW = XW + YW;
   localparam int NR = (XW + 1) / 2;
   localparam int NROWS = NR + 1;

   if (XW < 4) begin : g_bad_xw
      $error("booth_mul: XW must be at least 4");
   end
   if (YW < XW) begin : g_bad_yw
      $error("booth_mul: YW must be at least XW");
   end
   if (STAGES < 0 || STAGES > 2) begin : g_bad_st
      $error("booth_mul: STAGES must be 0, 1 or 2");
   end

   logic [PW-1:0] pp     [0:NR];
   logic [PW-1:0] cs0, cs1;
   logic [PW-1:0] add_a, add_b;
   logic [PW-1:0] sum;

   booth_pp_rows #(.XW(XW), .YW(YW)) rows_i (
      .x_i    (a_in),
      .y_i    (b_in),
      .rows_o (pp)
   );

   csa_tree #(.W(PW), .N(NROWS)) tree_i (
      .rows_i (pp),
      .row0_o (cs0),
      .row1_o (cs1)
   );

   // first cut: both carry-save rows
   if (STAGES >= 1) begin : g_cut1
      logic [PW-1:0] r0, r1;
      always_ff @(posedge clk) begin
         if (ce) begin
            r0 <= cs0;
            r1 <= cs1;
         end
      end
      assign add_a = r0;
      assign add_b = r1;
   end else begin : g_thru1
      assign add_a = cs0;
      assign add_b = cs1;
   end

   prefix_adder #(.W(PW)) add_i (
      .a_i (add_a),
      .b_i (add_b),
      .s_o (sum)
   );

   // second cut: the final sum
   if (STAGES >= 2) begin : g_cut2
      logic [PW-1:0] rs;
      always_ff @(posedge clk) begin
         if (ce) rs <= sum;
      end
      assign p_out = rs;
   end else begin : g_thru2
      assign p_out = sum;
   end

endmodule

// File: rtl/booth_mul_chk.sv
module booth_mul_chk #(
   parameter int XW     = 16,
   parameter int YW     = 16,
   parameter int STAGES = 2
)(
   input logic              clk,
   input logic              ce,
   input logic [XW-1:0]     a_in,
   input logic [YW-1:0]     b_in,
   input logic [XW+YW-1:0]  p_out
);

   localparam int PW = XW + YW;

   logic [1:0] fill;
   logic       primed;

   initial fill = 2'd0;
   always @(posedge clk) begin
      if (ce && fill != 2'd3) fill <= fill + 2'd1;
   end
   assign primed = (fill >= 2'd2);

   // operands aligned with the current output
   logic [XW-1:0] sa;
   logic [YW-1:0] sb;

   if (STAGES == 0) begin : g_s0
      assign sa = a_in;
      assign sb = b_in;
   end else if (STAGES == 1) begin : g_s1
      always @(posedge clk) if (ce) begin
         sa <= a_in;
         sb <= b_in;
      end
   end else begin : g_s2
      logic [XW-1:0] ha;
      logic [YW-1:0] hb;
      always @(posedge clk) if (ce) begin
         ha <= a_in;
         hb <= b_in;
         sa <= ha;
         sb <= hb;
      end
   end

   logic signed [PW-1:0] ref_p;
   assign ref_p = $signed({{YW{sa[XW-1]}}, sa}) * $signed({{XW{sb[YW-1]}}, sb});

   // R5
   product_chk: assert property (@(posedge clk) disable iff (!primed)
      p_out == ref_p);

   // R8
   zero_chk: assert property (@(posedge clk) disable iff (!primed)
      (sa == '0 || sb == '0) |-> (p_out == '0));

   // R1
   sign_chk: assert property (@(posedge clk) disable iff (!primed)
      (sa != '0 && sb != '0) |-> (p_out[PW-1] == (sa[XW-1] ^ sb[YW-1])));

   if (STAGES > 0) begin : g_hold
      // R6
      hold_chk: assert property (@(posedge clk) disable iff (!primed)
         !ce |=> $stable(p_out));
   end

endmodule

bind booth_mul booth_mul_chk #(.XW(XW), .YW(YW), .STAGES(STAGES)) chk_i (
   .clk   (clk),
   .ce    (ce),
   .a_in  (a_in),
   .b_in  (b_in),
   .p_out (p_out)
);

// File: tb/booth_mul_tb_top.sv
`timescale 1ns/1ps
module booth_mul_tb_top;

   localparam int WX = 12, WY = 16;
   localparam int SX = 4,  SY = 4;
   localparam int CX = 6,  CY = 8;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic          rst = 1'b1;
   logic          ce  = 1'b0;
   logic [WX-1:0] x   = '0;
   logic [WY-1:0] y   = '0;

   logic [WX+WY-1:0] p_w;
   logic [SX+SY-1:0] p_s;
   logic [CX+CY-1:0] p_c;

   booth_mul #(.XW(WX), .YW(WY), .STAGES(2)) dut_i (
      .clk(clk), .ce(ce), .a_in(x), .b_in(y), .p_out(p_w));

   booth_mul #(.XW(SX), .YW(SY), .STAGES(1)) small_i (
      .clk(clk), .ce(ce), .a_in(x[SX-1:0]), .b_in(y[SY-1:0]), .p_out(p_s));

   booth_mul #(.XW(CX), .YW(CY), .STAGES(0)) comb_i (
      .clk(clk), .ce(ce), .a_in(x[CX-1:0]), .b_in(y[CY-1:0]), .p_out(p_c));

   int     n_chk  = 0;
   int     n_fail = 0;
   string  tag    = "R1";
   bit     ended  = 1'b0;

   longint q_w[$];
   longint exp_w = 0, exp_s = 0;
   bit     v_w = 1'b0, v_s = 1'b0;

   function automatic longint prod_w();
      return longint'($signed(x)) * longint'($signed(y));
   endfunction
   function automatic longint prod_s();
      return longint'($signed(x[SX-1:0])) * longint'($signed(y[SY-1:0]));
   endfunction
   function automatic longint prod_c();
      return longint'($signed(x[CX-1:0])) * longint'($signed(y[CY-1:0]));
   endfunction

   // scoreboard: record what each enabled edge samples
   always @(posedge clk) begin
      if (!rst && ce) begin
         q_w.push_back(prod_w());
         if (q_w.size() == 2) begin
            exp_w = q_w.pop_front();
            v_w   = 1'b1;
         end
         exp_s = prod_s();
         v_s   = 1'b1;
      end
   end

   task automatic check(input string what, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   // monitor compares, then the driver applies the next operands
   task automatic step(input longint a, input longint b, input bit e);
      @(negedge clk);
      if (!rst) check("comb R3", longint'($signed(p_c)), prod_c());
      if (v_s)  check("one-stage R4", longint'($signed(p_s)), exp_s);
      if (v_w)  check("two-stage R5", longint'($signed(p_w)), exp_w);
      x  = a[WX-1:0];
      y  = b[WY-1:0];
      ce = e;
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(8 * 200000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      repeat (4) @(negedge clk);
      rst = 1'b0;

      // R1: every 4-bit operand pair
      tag = "R1";
      for (int a = -8; a < 8; a++)
         for (int b = -8; b < 8; b++)
            step(a, b, 1'b1);

      // R2: extreme operands on the wide instance
      tag = "R2";
      step(-2048, -32768, 1'b1);
      step(-1,    -32768, 1'b1);
      step(-2048,  32767, 1'b1);
      step( 2047,  32767, 1'b1);
      step( 2047, -32768, 1'b1);
      step(-2048,     -1, 1'b1);

      // R8: zero operands
      tag = "R8";
      step(0, -32768, 1'b1);
      step(-2048, 0, 1'b1);
      step(0, 0, 1'b1);

      // R6: stalls keep every result frozen
      tag = "R6";
      step(1234, -4321, 1'b1);
      step(-77, 999, 1'b1);
      step(55, 66, 1'b0);
      step(-55, -66, 1'b0);
      step(300, -300, 1'b0);
      step(-1, 1, 1'b1);
      step(7, 7, 1'b0);
      step(9, -9, 1'b1);

      // R7: random operands with random stalls
      tag = "R7";
      for (int i = 0; i < 800; i++)
         step(longint'($urandom), longint'($urandom), ($urandom % 4) != 0);

      tag = "R5";
      for (int i = 0; i < 4; i++) step(0, 0, 1'b1);

      finish_run();
   end

endmodule